// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pairwise Accumulate

This block multiplies two 64-bit operands as four independent signed 16-bit lanes. It forms all four full 32-bit two's-complement products and then returns one of three views of them, chosen per input beat by a 2-bit operation code. The first view keeps the lower half of each product. The second keeps the upper half. The third adds neighbouring products into two 32-bit sums.

The unit is a fixed-latency pipeline. A beat is accepted on every clock edge where `in_valid` is high, with no stall. Its result appears on `out_data` with `out_valid` high exactly `LATENCY` cycles later. Stage 1 registers the four lane products. Stage 2 registers the selected view. Any further latency comes from plain delay stages. When no beat completes, the output keeps its last value.

Top module: `packed_mul16`

## Requirements
- R1: Each operand is split into four signed 16-bit lanes, and lane i occupies bits [16i+15:16i] of the operands and of the low/high-view results.
- R2: With operation code 0 (low view), result lane i equals bits [15:0] of the signed product of operand lanes i.
- R3: With operation code 1 (high view), result lane i equals bits [31:16] of the signed product of operand lanes i.
- R4: With operation code 2 (pair sum), out_data[31:0] equals product0 + product1 and out_data[63:32] equals product2 + product3, each wrapping modulo 2^32.
- R5: With operation code 3 (reserved), out_data is all zeros.
- R6: out_valid is high in exactly the cycle that lies LATENCY (default 3) clock edges after an accepted beat, once per beat, and beats on consecutive cycles produce results on consecutive cycles.
- R7: While out_valid is low, out_data keeps its previous value, whatever the inputs do.
- R8: While reset is held and after it is released, out_valid is 0 and out_data is 0 until the first result arrives.
- R9: The most negative lane value is handled exactly: 0x8000 times 0x8000 gives a low half of 0x0000 and a high half of 0x4000, and the pair sum with all lanes at 0x8000 gives 0x80000000 in both halves.
- R10: The operation code is captured with each beat, so consecutive beats with different codes each return their own view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the inputs this cycle |
| in_op | input | 2 | View select: 0 low, 1 high, 2 pair sum, 3 zero |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result present on out_data this cycle |
| out_data | output | 64 | Selected view of the lane products |

## Verification
On every cycle, the bound checker runs a shadow pipeline. It compares the timing of `out_valid` against the accepted beats, and it compares each completed result against a view computed independently for the operation code of that beat. It also checks that `out_data` does not move while no result completes. The reset values, the exact corner values at the most negative lane, and lane placement with a distinct pattern in each lane can be seen only in the bench's directed scenarios. The same holds for a continuous stream with mixed codes and for an idle gap with busy inputs.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
    typedef enum logic [1:0] {
        OPC_LOW  = 2'd0,
        OPC_HIGH = 2'd1,
        OPC_MADD = 2'd2,
        OPC_NONE = 2'd3
    } opc_e;
endpackage

// File: rtl/pmul_lane.sv
// One signed lane multiplier with a registered full-width product.
module pmul_lane #(
    parameter int LANE_W = 16,
    localparam int PROD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] prod_c;

    always_comb prod_c = $signed(a) * $signed(b);

    always_ff @(posedge clk) begin
        if (!rst_n)  prod <= '0;
        else if (en) prod <= prod_c;
    end
endmodule

// File: rtl/pmul_format.sv
// Selects the low, high or pair-sum view of the products and registers it.
module pmul_format
    import pmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int NLANES = 4,
    localparam int PROD_W = 2 * LANE_W,
    localparam int WORD_W = LANE_W * NLANES,
    localparam int NPAIRS = NLANES / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  opc_e                     op,
    input  logic [NLANES*PROD_W-1:0] prods,
    output logic [WORD_W-1:0]        res
);
    logic [WORD_W-1:0] res_c;

    always_comb begin
        res_c = '0;
        unique case (op)
            OPC_LOW: begin
                for (int i = 0; i < NLANES; i++)
                    res_c[i*LANE_W +: LANE_W] = prods[i*PROD_W +: LANE_W];
            end
            OPC_HIGH: begin
                for (int i = 0; i < NLANES; i++)
                    res_c[i*LANE_W +: LANE_W] = prods[i*PROD_W + LANE_W +: LANE_W];
            end
            OPC_MADD: begin
                for (int j = 0; j < NPAIRS; j++)
                    res_c[j*PROD_W +: PROD_W] = prods[(2*j)*PROD_W +: PROD_W]
                                              + prods[(2*j+1)*PROD_W +: PROD_W];
            end
            OPC_NONE: res_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  res <= '0;
        else if (en) res <= res_c;
    end
endmodule

// File: rtl/pmul_delay.sv
// Valid-gated delay line; DEPTH may be zero.
module pmul_delay #(
    parameter int W     = 64,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_in,
    input  logic [W-1:0] d_in,
    output logic         v_out,
    output logic [W-1:0] d_out
);
    if (DEPTH == 0) begin : g_pass
        assign v_out = v_in;
        assign d_out = d_in;
    end else begin : g_pipe
        logic [DEPTH-1:0] v_q;
        logic [W-1:0]     d_q [DEPTH];

        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            logic         v_prev;
            logic [W-1:0] d_prev;
            if (k == 0) begin : g_first
                assign v_prev = v_in;
                assign d_prev = d_in;
            end else begin : g_next
                assign v_prev = v_q[k-1];
                assign d_prev = d_q[k-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) v_q[k] <= 1'b0;
                else        v_q[k] <= v_prev;
            end

            always_ff @(posedge clk) begin
                if (!rst_n)      d_q[k] <= '0;
                else if (v_prev) d_q[k] <= d_prev;
            end
        end

        assign v_out = v_q[DEPTH-1];
        assign d_out = d_q[DEPTH-1];
    end
endmodule

// File: rtl/packed_mul16.sv
// Four-lane signed multiplier, fixed latency LATENCY (>= 2).
module packed_mul16
    import pmul_pkg::*;
#(
    parameter int LANE_W  = 16,
    parameter int NLANES  = 4,
    parameter int LATENCY = 3,
    localparam int PROD_W = 2 * LANE_W,
    localparam int WORD_W = LANE_W * NLANES,
    localparam int EXTRA  = LATENCY - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic [NLANES*PROD_W-1:0] prods_q;
    logic                     s1_valid;
    opc_e                     s1_op;
    logic                     s2_valid;
    logic [WORD_W-1:0]        s2_res;

    // Stage 1: lane products
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        pmul_lane #(.LANE_W(LANE_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (in_valid),
            .a    (in_a[i*LANE_W +: LANE_W]),
            .b    (in_b[i*LANE_W +: LANE_W]),
            .prod (prods_q[i*PROD_W +: PROD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        s1_op <= OPC_LOW;
        else if (in_valid) s1_op <= opc_e'(in_op);
    end

    // Stage 2: view selection
    pmul_format #(.LANE_W(LANE_W), .NLANES(NLANES)) u_fmt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s1_valid),
        .op   (s1_op),
        .prods(prods_q),
        .res  (s2_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= s1_valid;
    end

    // Remaining latency
    pmul_delay #(.W(WORD_W), .DEPTH(EXTRA)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .v_in (s2_valid),
        .d_in (s2_res),
        .v_out(out_valid),
        .d_out(out_data)
    );
endmodule

// File: rtl/pmul_checker.sv
// Shadow-pipeline checker bound to packed_mul16.
module pmul_checker #(
    parameter int LANE_W  = 16,
    parameter int NLANES  = 4,
    parameter int LATENCY = 3,
    localparam int PROD_W = 2 * LANE_W,
    localparam int WORD_W = LANE_W * NLANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    logic [LATENCY-1:0] vsh;
    logic [1:0]         osh [LATENCY];
    logic [WORD_W-1:0]  esh [LATENCY];
    logic [WORD_W-1:0]  model_c;

    always_comb begin
        logic signed [PROD_W-1:0] p;
        logic [PROD_W-1:0]        acc;
        model_c = '0;
        acc     = '0;
        for (int i = 0; i < NLANES; i++) begin
            p = PROD_W'($signed(in_a[i*LANE_W +: LANE_W])) * PROD_W'($signed(in_b[i*LANE_W +: LANE_W]));
            if (in_op == 2'd0) model_c[i*LANE_W +: LANE_W] = p[LANE_W-1:0];
            if (in_op == 2'd1) model_c[i*LANE_W +: LANE_W] = p[PROD_W-1:LANE_W];
            if (in_op == 2'd2) begin
                if (i % 2 == 0) acc = p;
                else model_c[(i/2)*PROD_W +: PROD_W] = acc + p;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsh <= '0;
            for (int k = 0; k < LATENCY; k++) begin
                osh[k] <= '0;
                esh[k] <= '0;
            end
        end else begin
            vsh[0] <= in_valid;
            osh[0] <= in_op;
            esh[0] <= model_c;
            for (int k = 1; k < LATENCY; k++) begin
                vsh[k] <= vsh[k-1];
                osh[k] <= osh[k-1];
                esh[k] <= esh[k-1];
            end
        end
    end

    p_valid_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsh[LATENCY-1]);

    p_low_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && osh[LATENCY-1] == 2'd0) |-> out_data == esh[LATENCY-1]);

    p_high_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && osh[LATENCY-1] == 2'd1) |-> out_data == esh[LATENCY-1]);

    p_pair_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && osh[LATENCY-1] == 2'd2) |-> out_data == esh[LATENCY-1]);

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && osh[LATENCY-1] == 2'd3) |-> out_data == '0);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind packed_mul16 pmul_checker #(
    .LANE_W(LANE_W), .NLANES(NLANES), .LATENCY(LATENCY)
) u_pmul_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/packed_mul16_bench.sv
module packed_mul16_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int MAXB       = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0]  q_op [MAXB];
    logic [63:0] q_a  [MAXB];
    logic [63:0] q_b  [MAXB];
    int          q_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_mul16 #(.LATENCY(LAT)) u_packed_mul16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] expect_of(logic [1:0] op, logic [63:0] a, logic [63:0] b);
        logic signed [31:0] p [4];
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++)
            p[i] = 32'($signed(a[16*i +: 16])) * 32'($signed(b[16*i +: 16]));
        case (op)
            2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
            2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
            2'd2: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%016h expected=%016h", tag, got, exp);
        end
    endtask

    task automatic add_beat(logic [1:0] op, logic [63:0] a, logic [63:0] b);
        q_op[q_n] = op; q_a[q_n] = a; q_b[q_n] = b;
        q_n++;
    endtask

    // Drives q_* on consecutive cycles and checks every result cycle (R6).
    task automatic run_beats(string tag);
        for (int k = 0; k < q_n + LAT; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                check({tag, " R6 valid"}, 64'(out_valid), 64'd1);
                check(tag, out_data, expect_of(q_op[k-LAT], q_a[k-LAT], q_b[k-LAT]));
            end else begin
                check({tag, " R6 idle"}, 64'(out_valid), 64'd0);
            end
            in_valid = (k < q_n);
            if (k < q_n) begin
                in_op = q_op[k]; in_a = q_a[k]; in_b = q_b[k];
            end
        end
        in_valid = 1'b0;
        q_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R8 reset valid", 64'(out_valid), 64'd0);
        check("R8 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 post-reset valid", 64'(out_valid), 64'd0);
        check("R8 post-reset data", out_data, 64'd0);
    endtask

    task automatic t_lane_low();   // R1, R2
        add_beat(2'd0, 64'h0004_0003_0002_0001, 64'h0100_0010_0005_0007);
        add_beat(2'd0, 64'hFFFF_7FFF_1234_ABCD, 64'h0002_0003_5678_FFFF);
        run_beats("R1 R2 low view");
    endtask

    task automatic t_high();       // R3
        add_beat(2'd1, 64'h7FFF_FFFF_4000_8001, 64'h7FFF_FFFF_0004_0002);
        add_beat(2'd1, 64'hC000_0123_F00F_1000, 64'h3000_7654_0FF0_0010);
        run_beats("R3 high view");
    endtask

    task automatic t_madd();       // R4
        add_beat(2'd2, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
        add_beat(2'd2, 64'h7FFF_8001_FFFF_0001, 64'h7FFF_7FFF_0001_FFFF);
        run_beats("R4 pair sum");
    endtask

    task automatic t_reserved();   // R5
        add_beat(2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        run_beats("R5 reserved");
    endtask

    task automatic t_corner();     // R9
        add_beat(2'd0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        add_beat(2'd1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        add_beat(2'd2, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
        run_beats("R9 corner");
        check("R9 literal pair sum", expect_of(2'd2, {4{16'h8000}}, {4{16'h8000}}), 64'h8000_0000_8000_0000);
    endtask

    task automatic t_stream();     // R10, R6
        for (int i = 0; i < 10; i++)
            add_beat(2'(i % 4), {16'(i*977), 16'(i*31+5), 16'(-i*601), 16'(i+1)},
                                {16'(i*13-7), 16'(40000-i*911), 16'(i*257), 16'(-i-3)});
        run_beats("R10 mixed stream");
    endtask

    task automatic t_hold();       // R7
        logic [63:0] last;
        add_beat(2'd1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        run_beats("R7 setup");
        last = expect_of(2'd1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        for (int k = 0; k < 6; k++) begin
            in_valid = 1'b0; in_op = 2'(k); in_a = {4{16'(k*4099)}}; in_b = ~in_a;
            @(negedge clk);
            check("R7 idle valid", 64'(out_valid), 64'd0);
            check("R7 held data", out_data, last);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        q_n = 0;
        t_reset();
        t_lane_low();
        t_high();
        t_madd();
        t_reserved();
        t_corner();
        t_stream();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule